// File: doc/BRIEF.md
# DMA channel arm and trigger control

This block is the software-visible control front of a five-channel DMA controller. It sits on an 8-bit special-function-register bus and holds, for each channel, an arm bit and a pending software trigger. It also holds the 16-bit configuration address of channel 0 as two byte registers. The channel engines see a level `ch_start` per channel, held while a trigger is pending and the channel is armed. They also see a one-cycle `ch_abort` pulse and the `ch_armed` level. The engines answer with `ch_started` and `ch_done`, and each engine states whether it runs in a repetitive mode.

Software sets bits and hardware clears them. A written 1 arms a channel or posts a trigger, and a written 0 leaves the bit unchanged. A trigger is cleared when the engine reports that its transfer has started. An arm bit is cleared when the engine reports completion, but only in a non-repetitive mode. The top bit of the arm register is a write-only abort strobe. It cancels the channels named by the low bits of the same written byte.

Top module: `dma_trig_ctrl`

## Requirements
- R1: After reset every arm, trigger, reserved and configuration bit is 0, and `ch_armed`, `ch_start` and `ch_abort` are all 0.
- R2: A write to address 0xD6 with bit 7 = 0 sets arm bit n (bit n, n = 0..4) for each 1 in bits 4:0 and leaves bits written 0 unchanged. It stores bits 6:5 as plain storage, and reads return {0, bits 6:5, arm bits 4:0}. Bit 7 always reads 0.
- R3: A write to address 0xD7 sets trigger bit n for each 1 in bits 4:0 and leaves bits written 0 unchanged. Reads return the trigger bits in 4:0, and bits 7:5 read 0.
- R4: `ch_start[n]` is 1 exactly while trigger bit n and arm bit n are both 1. A trigger posted to a disarmed channel stays pending and drives no start until the channel is armed.
- R5: `ch_started[n]` = 1 at a clock edge clears trigger bit n.
- R6: `ch_done[n]` = 1 at a clock edge clears arm bit n when `ch_repeat[n]` = 0. When `ch_repeat[n]` = 1, arm bit n stays set.
- R7: If a software set and a hardware clear of the same arm or trigger bit fall on the same edge, the bit ends up set.
- R8: A write to 0xD6 with bit 7 = 1 clears the arm bit and the trigger bit of each channel whose bit in 4:0 is 1, and arms no channel. `ch_abort` carries that channel mask for exactly the one cycle after the write edge, whether or not the channel was armed.
- R9: Address 0xD4 holds configuration address bits 7:0 and 0xD5 holds bits 15:8. Both are read/write, and the full value drives `cfg0_addr`.
- R10: Reads of any address other than 0xD4 to 0xD7 return 0, and writes to such addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register address |
| sfr_we | input | 1 | Write strobe, one write per cycle |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for `sfr_addr`, combinational |
| ch_started | input | 5 | Engine n has started the transfer |
| ch_done | input | 5 | Engine n has completed the transfer |
| ch_repeat | input | 5 | Engine n runs in a repetitive mode |
| ch_armed | output | 5 | Arm bit per channel |
| ch_start | output | 5 | Start request per channel, held until started |
| ch_abort | output | 5 | One-cycle abort pulse per channel |
| cfg0_addr | output | 16 | Channel-0 configuration address |

## Verification
The bench builds the block with its default parameters: five channels, an 8-bit bus and the four addresses 0xD4 to 0xD7. With five channels the two reserved arm bits are present, so a read can show the reserved bits and the zero abort bit in the same byte. The trigger read shows three reserved bits that must read 0. The bench drives same-edge collisions of a software set with `ch_done` and with `ch_started`. It sends aborts aimed at armed and at unarmed channels, and it runs one channel in repetitive mode next to non-repetitive ones.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;
  localparam int          SFR_AW      = 8;
  localparam int          SFR_DW      = 8;
  localparam int          NUM_CH      = 5;
  localparam logic [7:0]  CFG_LO_ADR  = 8'hD4;
  localparam logic [7:0]  CFG_HI_ADR  = 8'hD5;
  localparam logic [7:0]  ARM_ADR     = 8'hD6;
  localparam logic [7:0]  TRIG_ADR    = 8'hD7;
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dma_ch_slice.sv
module dma_ch_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_set,
  input  logic abort_sel,
  input  logic req_set,
  input  logic started,
  input  logic done,
  input  logic repeat_mode,
  output logic armed,
  output logic req_pend,
  output logic start,
  output logic abort_pulse
);
  logic arm_q, arm_d, arm_en;
  logic req_q, req_d, req_en;
  logic abo_q;

  // next state: hardware clears first, software actions override
  always_comb begin
    arm_d = arm_q;
    if (done && !repeat_mode) arm_d = 1'b0;
    if (abort_sel)            arm_d = 1'b0;
    else if (arm_set)         arm_d = 1'b1;

    req_d = req_q;
    if (started)              req_d = 1'b0;
    if (abort_sel)            req_d = 1'b0;
    else if (req_set)         req_d = 1'b1;

    arm_en = (arm_d != arm_q);
    req_en = (req_d != req_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      req_q <= 1'b0;
      abo_q <= 1'b0;
    end else begin
      if (arm_en) arm_q <= arm_d;
      if (req_en) req_q <= req_d;
      abo_q <= abort_sel;
    end
  end

  assign armed       = arm_q;
  assign req_pend    = req_q;
  assign start       = arm_q & req_q;
  assign abort_pulse = abo_q;

  // R8
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (!armed && !req_pend));
  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !repeat_mode && !arm_set) |=> !armed);
  // R6
  repeat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && repeat_mode && !abort_sel) |=> armed);
  // R5
  started_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !req_set && !abort_sel) |=> !req_pend);
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_set && !abort_sel) |=> armed);
endmodule

// File: rtl/dma_sfr_decode.sv
module dma_sfr_decode #(
  parameter int         NCH      = dma_trig_pkg::NUM_CH,
  parameter int         DW       = dma_trig_pkg::SFR_DW,
  parameter int         AW       = dma_trig_pkg::SFR_AW,
  parameter logic [7:0] CFG_LO_A = dma_trig_pkg::CFG_LO_ADR,
  parameter logic [7:0] CFG_HI_A = dma_trig_pkg::CFG_HI_ADR,
  parameter logic [7:0] ARM_A    = dma_trig_pkg::ARM_ADR,
  parameter logic [7:0] TRIG_A   = dma_trig_pkg::TRIG_ADR,
  localparam int        RSV_W    = DW - 1 - NCH
) (
  input  logic [AW-1:0]    sfr_addr,
  input  logic             sfr_we,
  input  logic [DW-1:0]    sfr_wdata,
  input  logic [NCH-1:0]   arm_vec,
  input  logic [NCH-1:0]   req_vec,
  input  logic [RSV_W-1:0] rsv_val,
  input  logic [2*DW-1:0]  cfg_val,
  output logic [NCH-1:0]   arm_set,
  output logic [NCH-1:0]   req_set,
  output logic [NCH-1:0]   abort_sel,
  output logic             rsv_we,
  output logic             cfg_lo_we,
  output logic             cfg_hi_we,
  output logic [DW-1:0]    sfr_rdata
);
  logic hit_arm, hit_trig, hit_lo, hit_hi, abort_bit;

  always_comb begin
    hit_arm   = (sfr_addr == AW'(ARM_A));
    hit_trig  = (sfr_addr == AW'(TRIG_A));
    hit_lo    = (sfr_addr == AW'(CFG_LO_A));
    hit_hi    = (sfr_addr == AW'(CFG_HI_A));
    abort_bit = sfr_wdata[DW-1];

    rsv_we    = sfr_we && hit_arm;
    cfg_lo_we = sfr_we && hit_lo;
    cfg_hi_we = sfr_we && hit_hi;
    arm_set   = (rsv_we && !abort_bit) ? sfr_wdata[NCH-1:0] : '0;
    abort_sel = (rsv_we &&  abort_bit) ? sfr_wdata[NCH-1:0] : '0;
    req_set   = (sfr_we && hit_trig)   ? sfr_wdata[NCH-1:0] : '0;

    sfr_rdata = '0;
    if (hit_arm)       sfr_rdata = {1'b0, rsv_val, arm_vec};
    else if (hit_trig) sfr_rdata = {{(DW-NCH){1'b0}}, req_vec};
    else if (hit_lo)   sfr_rdata = cfg_val[DW-1:0];
    else if (hit_hi)   sfr_rdata = cfg_val[2*DW-1:DW];
  end
endmodule

// File: rtl/dma_trig_ctrl.sv
module dma_trig_ctrl #(
  parameter int  NCH    = dma_trig_pkg::NUM_CH,
  parameter int  DW     = dma_trig_pkg::SFR_DW,
  parameter int  AW     = dma_trig_pkg::SFR_AW,
  localparam int RSV_W  = DW - 1 - NCH,
  localparam int CFG_W  = 2 * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    sfr_addr,
  input  logic             sfr_we,
  input  logic [DW-1:0]    sfr_wdata,
  output logic [DW-1:0]    sfr_rdata,
  input  logic [NCH-1:0]   ch_started,
  input  logic [NCH-1:0]   ch_done,
  input  logic [NCH-1:0]   ch_repeat,
  output logic [NCH-1:0]   ch_armed,
  output logic [NCH-1:0]   ch_start,
  output logic [NCH-1:0]   ch_abort,
  output logic [CFG_W-1:0] cfg0_addr
);
  logic              rst_ni;
  logic [NCH-1:0]    arm_set, req_set, abort_sel, req_vec;
  logic              rsv_we, cfg_lo_we, cfg_hi_we;
  logic [RSV_W-1:0]  rsv_q, rsv_d;
  logic [CFG_W-1:0]  cfg_q, cfg_d;

  dma_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  dma_sfr_decode #(.NCH(NCH), .DW(DW), .AW(AW)) u_dec (
    .sfr_addr  (sfr_addr),
    .sfr_we    (sfr_we),
    .sfr_wdata (sfr_wdata),
    .arm_vec   (ch_armed),
    .req_vec   (req_vec),
    .rsv_val   (rsv_q),
    .cfg_val   (cfg_q),
    .arm_set   (arm_set),
    .req_set   (req_set),
    .abort_sel (abort_sel),
    .rsv_we    (rsv_we),
    .cfg_lo_we (cfg_lo_we),
    .cfg_hi_we (cfg_hi_we),
    .sfr_rdata (sfr_rdata)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    dma_ch_slice u_ch (
      .clk         (clk),
      .rst_n       (rst_ni),
      .arm_set     (arm_set[n]),
      .abort_sel   (abort_sel[n]),
      .req_set     (req_set[n]),
      .started     (ch_started[n]),
      .done        (ch_done[n]),
      .repeat_mode (ch_repeat[n]),
      .armed       (ch_armed[n]),
      .req_pend    (req_vec[n]),
      .start       (ch_start[n]),
      .abort_pulse (ch_abort[n])
    );
  end

  always_comb begin
    rsv_d = sfr_wdata[DW-2:NCH];
    cfg_d = cfg_q;
    if (cfg_lo_we) cfg_d[DW-1:0]     = sfr_wdata;
    if (cfg_hi_we) cfg_d[CFG_W-1:DW] = sfr_wdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsv_q <= '0;
      cfg_q <= '0;
    end else begin
      if (rsv_we)                 rsv_q <= rsv_d;
      if (cfg_lo_we || cfg_hi_we) cfg_q <= cfg_d;
    end
  end

  assign cfg0_addr = cfg_q;

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!cfg_lo_we && !cfg_hi_we) |=> $stable(cfg0_addr));
  // R4
  start_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ((ch_start & ~ch_armed) == '0));
endmodule

// File: tb/test_dma_trig_ctrl.sv
`timescale 1ns/1ps
module test_dma_trig_ctrl;
  localparam int NCH = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
  logic        sfr_we;
  logic [4:0]  ch_started, ch_done, ch_repeat, ch_armed, ch_start, ch_abort;
  logic [15:0] cfg0_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  dma_trig_ctrl i_dma_trig_ctrl (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ch_started(ch_started),
    .ch_done(ch_done), .ch_repeat(ch_repeat), .ch_armed(ch_armed),
    .ch_start(ch_start), .ch_abort(ch_abort), .cfg0_addr(cfg0_addr)
  );

  // kinds: 0 rdata, 1 armed, 2 start, 3 abort, 4 cfg0_addr
  function automatic logic [15:0] sample(int kind);
    case (kind)
      0:       return {8'h00, sfr_rdata};
      1:       return {11'h0, ch_armed};
      2:       return {11'h0, ch_start};
      3:       return {11'h0, ch_abort};
      default: return cfg0_addr;
    endcase
  endfunction

  // monitor: after each rising edge, compare everything expected for it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = sb.pop_front();
        act = sample(it.kind);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(int kind, logic [15:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic drive(logic we, logic [7:0] a, logic [7:0] d,
                       logic [4:0] st, logic [4:0] dn);
    @(negedge clk);
    sfr_we = we; sfr_addr = a; sfr_wdata = d;
    ch_started = st; ch_done = dn;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    drive(1'b1, a, d, 5'h0, 5'h0);
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    drive(1'b0, a, 8'h00, 5'h0, 5'h0);
    expect_val(0, {8'h00, exp}, tag);
  endtask

  initial begin
    rst_n = 1'b0; sfr_we = 1'b0; sfr_addr = 8'h00; sfr_wdata = 8'h00;
    ch_started = '0; ch_done = '0; ch_repeat = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // reset state
    rd(8'hD6, 8'h00, "R1 arm reset");
    expect_val(1, 16'h0, "R1 armed reset");
    expect_val(2, 16'h0, "R1 start reset");
    expect_val(3, 16'h0, "R1 abort reset");
    rd(8'hD7, 8'h00, "R1 trig reset");
    rd(8'hD4, 8'h00, "R1 cfg lo reset");
    rd(8'hD5, 8'h00, "R1 cfg hi reset");

    // configuration address
    wr(8'hD4, 8'h34);
    wr(8'hD5, 8'h12);
    expect_val(4, 16'h1234, "R9 cfg0_addr");
    rd(8'hD4, 8'h34, "R9 cfg lo read");
    rd(8'hD5, 8'h12, "R9 cfg hi read");

    // triggers on disarmed channels stay pending
    wr(8'hD7, 8'hFF);
    rd(8'hD7, 8'h1F, "R3 trig read, reserved zero");
    expect_val(2, 16'h0, "R4 no start while disarmed");

    // arm ch0 and ch2
    wr(8'hD6, 8'h05);
    expect_val(1, 16'h05, "R2 arm set");
    expect_val(2, 16'h05, "R4 start when armed");
    rd(8'hD6, 8'h05, "R2 arm read");

    // zeros have no effect
    wr(8'hD6, 8'h00);
    expect_val(1, 16'h05, "R2 zero write to arm");
    wr(8'hD7, 8'h00);
    rd(8'hD7, 8'h1F, "R3 zero write to trig");

    // started clears trigger of ch0
    drive(1'b0, 8'h00, 8'h00, 5'h01, 5'h00);
    rd(8'hD7, 8'h1E, "R5 started clears trig");
    expect_val(2, 16'h04, "R5 start drops");

    // completion, non-repetitive ch0
    drive(1'b0, 8'h00, 8'h00, 5'h00, 5'h01);
    rd(8'hD6, 8'h04, "R6 done disarms");

    // completion, repetitive ch2
    ch_repeat = 5'h04;
    drive(1'b0, 8'h00, 8'h00, 5'h00, 5'h04);
    expect_val(1, 16'h04, "R6 repeat keeps arm");

    // software set beats hardware clear
    wr(8'hD6, 8'h02);
    expect_val(1, 16'h06, "R2 arm ch1");
    drive(1'b1, 8'hD6, 8'h02, 5'h00, 5'h02);
    expect_val(1, 16'h06, "R7 set wins over done");
    drive(1'b1, 8'hD7, 8'h02, 5'h02, 5'h00);
    rd(8'hD7, 8'h1E, "R7 set wins over started");
    expect_val(2, 16'h06, "R4 start armed and pending");

    // abort an armed channel
    wr(8'hD6, 8'h82);
    expect_val(3, 16'h02, "R8 abort pulse ch1");
    expect_val(1, 16'h04, "R8 abort disarms ch1");
    rd(8'hD6, 8'h04, "R8 abort bit reads 0");
    expect_val(3, 16'h00, "R8 abort pulse one cycle");
    rd(8'hD7, 8'h1C, "R8 abort clears trig");

    // abort an unarmed channel
    wr(8'hD6, 8'h88);
    expect_val(3, 16'h08, "R8 abort pulse unarmed ch3");
    expect_val(1, 16'h04, "R8 abort arms nothing");
    rd(8'hD7, 8'h14, "R8 abort clears ch3 trig");

    // reserved arm bits
    wr(8'hD6, 8'h64);
    rd(8'hD6, 8'h64, "R2 reserved bits stored");

    // unmapped address
    rd(8'hD3, 8'h00, "R10 unmapped read");
    wr(8'hD3, 8'hFF);
    rd(8'hD6, 8'h64, "R10 unmapped write ignored arm");
    rd(8'hD4, 8'h34, "R10 unmapped write ignored cfg");
    rd(8'hD7, 8'h14, "R10 unmapped write ignored trig");

    drive(1'b0, 8'h00, 8'h00, 5'h00, 5'h00);
    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule